// File: doc/BRIEF.md
# Two-Bit Fixed-Point Divider

This block divides an unsigned two-bit dividend by an unsigned two-bit divisor and returns a three-bit fixed-point quotient. The upper two bits hold the integer part and the lowest bit holds a fraction worth one half. The quotient is always rounded down to the next lower half. A zero divisor yields the all-ones code, which reads as 11.1.

The arithmetic core is purely combinational. A thin clocked stage around it accepts operands with `in_valid` and presents the quotient with `out_valid` one clock later. The quotient register keeps its last value until the next accepted operand pair. Operand width and fraction width are parameters, and their defaults give the two-bit by two-bit, one-fraction-bit form.

Top module: `halfstep_divider`

## Requirements
- R1: For a nonzero divisor, `quotient` equals floor(2*dividend/divisor) as an unsigned 3-bit value. Bits [2:1] are the integer part and bit [0] is the half-weight fraction.
- R2: Rounding is toward the lower half, never upward. For example, 1 divided by 3 gives 3'b000, and 2 divided by 3 gives 3'b001.
- R3: A divisor of zero gives 3'b111 for every dividend, including a dividend of zero.
- R4: `out_valid` is high in the cycle right after a rising clock edge at which `in_valid` was high. It is low after an edge at which `in_valid` was low.
- R5: While `in_valid` is low, `quotient` keeps the value it last loaded, whatever is on `dividend` and `divisor`.
- R6: While `rst_n` is low, and before the first accepted pair, `out_valid` is 0 and `quotient` is 3'b000.
- R7: The largest quotients are exact. 3 divided by 1 gives 3'b110, and 3 divided by 2 gives 3'b011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are accepted at this clock edge |
| dividend | input | 2 | Unsigned numerator |
| divisor | input | 2 | Unsigned denominator |
| out_valid | output | 1 | Quotient register holds a fresh result |
| quotient | output | 3 | Fixed-point result: integer part [2:1], half bit [0] |

## Verification
Every result here is due exactly one rising edge after the operands are presented with `in_valid` high. Both `quotient` and `out_valid` come from the same register stage, so no result ever arrives with a different delay. The bench drives each operand pair on a falling edge, waits for one rising edge, and samples at the next falling edge. For the hold behaviour, it drives new operands with `in_valid` low, lets a rising edge pass, and confirms that the output is unchanged half a cycle later.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
    localparam int unsigned HSD_OPW   = 2;
    localparam int unsigned HSD_FRACW = 1;
endpackage

// File: rtl/hsd_long_div.sv
module hsd_long_div #(
    parameter int unsigned OPW   = 2,
    parameter int unsigned FRACW = 1,
    localparam int unsigned QW   = OPW + FRACW,
    localparam int unsigned PW   = QW + OPW + 1
) (
    input  logic [OPW-1:0] num,
    input  logic [OPW-1:0] den,
    output logic [QW-1:0]  quo
);
    logic [QW-1:0]  scaled;
    logic [QW-1:0]  bits_d;
    logic [OPW:0]   rem_d;
    logic [PW-1:0]  lo_prod;
    logic [PW-1:0]  hi_prod;

    assign scaled = {num, {FRACW{1'b0}}};

    // restoring long division, one quotient bit per step
    always_comb begin
        rem_d  = '0;
        bits_d = '0;
        for (int i = QW - 1; i >= 0; i--) begin
            rem_d = {rem_d[OPW-1:0], scaled[i]};
            if (rem_d >= {1'b0, den}) begin
                rem_d     = rem_d - {1'b0, den};
                bits_d[i] = 1'b1;
            end
        end
    end

    assign quo = bits_d;

    assign lo_prod = PW'(bits_d) * PW'(den);
    assign hi_prod = (PW'(bits_d) + PW'(1)) * PW'(den);

    always_comb begin
        if (den != '0) begin
            assert_floor_bounds_R1: assert (lo_prod <= PW'(scaled) && PW'(scaled) < hi_prod);
            assert_rem_below_den_R2: assert (rem_d < {1'b0, den});
        end
    end
endmodule

// File: rtl/hsd_sat_select.sv
module hsd_sat_select #(
    parameter int unsigned OPW = 2,
    parameter int unsigned QW  = 3
) (
    input  logic [OPW-1:0] den,
    input  logic [QW-1:0]  raw,
    output logic [QW-1:0]  res
);
    logic den_zero;

    assign den_zero = (den == '0);

    always_comb begin
        res = raw;
        if (den_zero) begin
            res = '1;
        end
    end
endmodule

// File: rtl/hsd_out_stage.sv
module hsd_out_stage #(
    parameter int unsigned QW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [QW-1:0] res,
    output logic          vld,
    output logic [QW-1:0] held
);
    typedef struct packed {
        logic          vld;
        logic [QW-1:0] quo;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = take;
        if (take) begin
            st_d.quo = res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld  = st_q.vld;
    assign held = st_q.quo;

    assert_valid_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> vld);
    assert_valid_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !vld);
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(held));
    assert_load_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> held == $past(res));
endmodule

// File: rtl/halfstep_divider.sv
module halfstep_divider #(
    parameter int unsigned OPW   = hsd_pkg::HSD_OPW,
    parameter int unsigned FRACW = hsd_pkg::HSD_FRACW,
    localparam int unsigned QW   = OPW + FRACW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [OPW-1:0] dividend,
    input  logic [OPW-1:0] divisor,
    output logic           out_valid,
    output logic [QW-1:0]  quotient
);
    logic [QW-1:0] raw_quo;
    logic [QW-1:0] sel_quo;

    hsd_long_div #(.OPW(OPW), .FRACW(FRACW)) u_div (
        .num (dividend),
        .den (divisor),
        .quo (raw_quo)
    );

    hsd_sat_select #(.OPW(OPW), .QW(QW)) u_sat (
        .den (divisor),
        .raw (raw_quo),
        .res (sel_quo)
    );

    hsd_out_stage #(.QW(QW)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (in_valid),
        .res   (sel_quo),
        .vld   (out_valid),
        .held  (quotient)
    );

    assert_zero_div_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && divisor == '0) |=> quotient == '1);
    assert_reset_clear_R6: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && quotient == '0));
endmodule

// File: tb/halfstep_divider_tb.sv
module halfstep_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] dividend = '0;
    logic [1:0] divisor = '0;
    logic       out_valid;
    logic [2:0] quotient;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    halfstep_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .dividend  (dividend),
        .divisor   (divisor),
        .out_valid (out_valid),
        .quotient  (quotient)
    );

    function automatic logic [2:0] ref_quo(input int a, input int b);
        if (b == 0) return 3'b111;
        return 3'((2 * a) / b);
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        @(negedge clk);
        dividend = 2'(a);
        divisor  = 2'(b);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R6 valid in reset", {3'b0, out_valid}, 4'h0);
        check("R6 quotient in reset", {1'b0, quotient}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 valid after reset", {3'b0, out_valid}, 4'h0);
        check("R6 quotient after reset", {1'b0, quotient}, 4'h0);
    endtask

    task automatic t_all_pairs();
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                apply(a, b);
                if (b == 0) check("R3 zero divisor", {1'b0, quotient}, 4'h7);
                else check("R1 quotient", {1'b0, quotient}, {1'b0, ref_quo(a, b)});
                check("R4 valid high", {3'b0, out_valid}, 4'h1);
            end
        end
    endtask

    task automatic t_corners();
        apply(1, 3);
        check("R2 1/3 rounds down", {1'b0, quotient}, 4'h0);
        apply(2, 3);
        check("R2 2/3 rounds down", {1'b0, quotient}, 4'h1);
        apply(0, 0);
        check("R3 0/0", {1'b0, quotient}, 4'h7);
        apply(3, 1);
        check("R7 3/1", {1'b0, quotient}, 4'h6);
        apply(3, 2);
        check("R7 3/2", {1'b0, quotient}, 4'h3);
    endtask

    task automatic t_latency();
        apply(2, 1);
        check("R4 result one cycle later", {1'b0, quotient}, 4'h4);
        check("R4 valid one cycle later", {3'b0, out_valid}, 4'h1);
        @(negedge clk);
        check("R4 valid drops", {3'b0, out_valid}, 4'h0);
    endtask

    task automatic t_hold();
        apply(3, 3);
        check("R5 loaded", {1'b0, quotient}, 4'h2);
        dividend = 2'd3;
        divisor  = 2'd1;
        @(negedge clk);
        check("R5 held with idle input", {1'b0, quotient}, 4'h2);
        divisor = 2'd0;
        @(negedge clk);
        check("R5 held with zero divisor idle", {1'b0, quotient}, 4'h2);
        check("R4 valid low while idle", {3'b0, out_valid}, 4'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_all_pairs();
        t_corners();
        t_latency();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule